// File: doc/BRIEF.md
# Store-Load Ordering Violation Detector

This block guards memory ordering in an out-of-order core. When a store's effective address becomes known at execute, the block looks at every load-queue slot that was allocated after the store. These are the slots from the load-queue position captured when the store was dispatched, up to the current load tail, and the range may wrap around the end of the ring. If any of those loads has already produced an address in the same coarse region as the store, it may have read stale data. The oldest such load is latched as the violator, and a one-cycle fault pulse tells the pipeline to refetch.

The address comparison is conservative on purpose. Only the bits above a configurable region shift are compared, so two accesses inside the same 256-byte region count as overlapping. A load slot that has not yet executed carries a reserved all-ones address and never matches. Once a violator is latched, further scans are suppressed until the consumer collects the violator with a take strobe; that strobe clears the latch. A zero-size store is dropped without any effect. A store-conditional of nonzero size produces a pulse that marks it eligible for writeback, whether or not a violation is found. The whole scan is a parallel compare under a circular range mask followed by an oldest-first pick, and its result is registered one cycle after the request.

Top module: `ordering_guard`

## Requirements
- R1: A store request (`st_valid_i`, nonzero size) issued while no violator is latched, with a matching load inside the scan range, raises `fault_o` for exactly the next cycle and sets `viol_valid_o` at the same edge.
- R2: The scan range starts at `st_lq_pos_i` and stops just before `lq_tail_i`, wrapping modulo the queue depth. When the position equals the tail the range is empty, and loads outside the range never cause a fault.
- R3: Two addresses match when they are equal after a right shift by 8 bits. Addresses that differ in bit 8 or above do not match.
- R4: When several loads in range match, `viol_idx_o` is the one nearest the store's recorded position in ring order.
- R5: While `viol_valid_o` is high, a store request causes no scan: `fault_o` stays low and `viol_idx_o` keeps its value.
- R6: `viol_take_i` asserted while `viol_valid_o` is high clears `viol_valid_o` at the next edge. Until then the index stays stable.
- R7: A store request with size 0 has no effect: no fault, no latch and no writeback pulse.
- R8: A store request with `st_cond_i` high and nonzero size pulses `wb_inc_o` for the next cycle. This happens independently of any match or latch state.
- R9: A load slot whose address equals the all-ones invalid value never matches, even when its region equals the store's region.
- R10: After reset, `fault_o`, `wb_inc_o` and `viol_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid_i | input | 1 | Store execute request |
| st_lq_pos_i | input | IDX_W (3) | Load-queue position recorded with the store (start of scan) |
| st_addr_i | input | ADDR_W (32) | Store effective address |
| st_size_i | input | SIZE_W (4) | Store access size in bytes; 0 means no access |
| st_cond_i | input | 1 | Store is a store-conditional |
| lq_tail_i | input | IDX_W (3) | Current load-queue tail (scan end, exclusive) |
| lq_addr_i | input | LQ_DEPTH*ADDR_W (256) | Addresses of all load slots, slot i at bits [i*ADDR_W +: ADDR_W] |
| viol_take_i | input | 1 | Read-and-clear strobe for the latched violator |
| viol_valid_o | output | 1 | A violator is latched |
| viol_idx_o | output | IDX_W (3) | Load-queue index of the latched violator |
| fault_o | output | 1 | One-cycle ordering-fault pulse for the executing store |
| wb_inc_o | output | 1 | One-cycle pulse: store-conditional became writeback-eligible |

## Verification
The reference model walks the ring one slot at a time from the store's position and stops at the first match or at the tail. Its result is compared with the parallel masked pick on every cycle. Directed cases place matches on both sides of the wrap point, exactly at the tail slot, before the start slot and inside an empty range. Together these separate an inclusive bound from an exclusive one and a plain compare from a modular one. Paired addresses that differ only below bit 8, or first at bit 8, confirm the region boundary, and an all-ones slot against an all-ones-region store shows the invalid marker is honoured. Randomised stores with random take strobes, sizes and conditional flags then exercise latch suppression against collection in every ordering.

// File: rtl/svd_pkg.sv
package svd_pkg;

  // Position reached after stepping 'step' slots forward from 'base' on a ring.
  function automatic int ring_add(int base, int step, int depth);
    return (base + step) % depth;
  endfunction

  // Number of forward steps from 'from_pos' to 'to_pos' on a ring.
  function automatic int ring_dist(int from_pos, int to_pos, int depth);
    return (to_pos - from_pos + depth) % depth;
  endfunction

  // Coarse region tag of an address.
  function automatic logic [63:0] region_of(logic [63:0] addr, int shift);
    return addr >> shift;
  endfunction

endpackage

// File: rtl/svd_range_mask.sv
module svd_range_mask #(
  parameter int LQ_DEPTH = 8,
  parameter int IDX_W    = 3
) (
  input  logic [IDX_W-1:0]    start_i,
  input  logic [IDX_W-1:0]    tail_i,
  output logic [LQ_DEPTH-1:0] mask_o
);
  import svd_pkg::*;

  int span;
  assign span = ring_dist(int'(start_i), int'(tail_i), LQ_DEPTH);

  // A slot is in range when its forward distance from the start is below the span.
  for (genvar g = 0; g < LQ_DEPTH; g++) begin : g_slot
    assign mask_o[g] = ring_dist(int'(start_i), g, LQ_DEPTH) < span;
  end

endmodule

// File: rtl/svd_region_cmp.sv
module svd_region_cmp #(
  parameter int              LQ_DEPTH = 8,
  parameter int              ADDR_W   = 32,
  parameter int              SHIFT    = 8,
  parameter logic [ADDR_W-1:0] INVALID = '1
) (
  input  logic [LQ_DEPTH*ADDR_W-1:0] lq_addr_i,
  input  logic [ADDR_W-1:0]          st_addr_i,
  output logic [LQ_DEPTH-1:0]        match_o
);
  import svd_pkg::*;

  logic [63:0] st_region;
  assign st_region = region_of(64'(st_addr_i), SHIFT);

  for (genvar g = 0; g < LQ_DEPTH; g++) begin : g_cmp
    logic [ADDR_W-1:0] slot_addr;
    logic              slot_live;
    assign slot_addr  = lq_addr_i[g*ADDR_W +: ADDR_W];
    assign slot_live  = (slot_addr != INVALID);
    assign match_o[g] = slot_live && (region_of(64'(slot_addr), SHIFT) == st_region);
  end

endmodule

// File: rtl/svd_oldest_pick.sv
module svd_oldest_pick #(
  parameter int LQ_DEPTH = 8,
  parameter int IDX_W    = 3
) (
  input  logic [LQ_DEPTH-1:0] cand_i,
  input  logic [IDX_W-1:0]    start_i,
  output logic                any_o,
  output logic [IDX_W-1:0]    pick_o
);
  import svd_pkg::*;

  // Walk offsets from farthest to nearest so the nearest candidate wins.
  always_comb begin
    any_o  = 1'b0;
    pick_o = '0;
    for (int k = LQ_DEPTH - 1; k >= 0; k--) begin
      if (cand_i[ring_add(int'(start_i), k, LQ_DEPTH)]) begin
        any_o  = 1'b1;
        pick_o = IDX_W'(ring_add(int'(start_i), k, LQ_DEPTH));
      end
    end
  end

endmodule

// File: rtl/ordering_guard.sv
module ordering_guard #(
  parameter int LQ_DEPTH = 8,
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 4,
  parameter int SHIFT    = 8,
  parameter int IDX_W    = $clog2(LQ_DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       st_valid_i,
  input  logic [IDX_W-1:0]           st_lq_pos_i,
  input  logic [ADDR_W-1:0]          st_addr_i,
  input  logic [SIZE_W-1:0]          st_size_i,
  input  logic                       st_cond_i,
  input  logic [IDX_W-1:0]           lq_tail_i,
  input  logic [LQ_DEPTH*ADDR_W-1:0] lq_addr_i,
  input  logic                       viol_take_i,
  output logic                       viol_valid_o,
  output logic [IDX_W-1:0]           viol_idx_o,
  output logic                       fault_o,
  output logic                       wb_inc_o
);

  localparam logic [ADDR_W-1:0] INVALID_ADDR = '1;

  logic [LQ_DEPTH-1:0] range_mask;
  logic [LQ_DEPTH-1:0] region_hit;
  logic [LQ_DEPTH-1:0] cand;
  logic                hit_any;
  logic [IDX_W-1:0]    hit_idx;
  logic                st_real;
  logic                scan_go;
  logic                viol_q;
  logic [IDX_W-1:0]    idx_q;
  logic                fault_q;
  logic                wb_q;

  svd_range_mask #(.LQ_DEPTH(LQ_DEPTH), .IDX_W(IDX_W)) u_range (
    .start_i (st_lq_pos_i),
    .tail_i  (lq_tail_i),
    .mask_o  (range_mask)
  );

  svd_region_cmp #(
    .LQ_DEPTH(LQ_DEPTH), .ADDR_W(ADDR_W), .SHIFT(SHIFT), .INVALID(INVALID_ADDR)
  ) u_cmp (
    .lq_addr_i (lq_addr_i),
    .st_addr_i (st_addr_i),
    .match_o   (region_hit)
  );

  assign cand = range_mask & region_hit;

  svd_oldest_pick #(.LQ_DEPTH(LQ_DEPTH), .IDX_W(IDX_W)) u_pick (
    .cand_i  (cand),
    .start_i (st_lq_pos_i),
    .any_o   (hit_any),
    .pick_o  (hit_idx)
  );

  // A zero-size store carries no access; a latched violator blocks scanning.
  assign st_real = st_valid_i && (st_size_i != '0);
  assign scan_go = st_real && !viol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q  <= 1'b0;
      idx_q   <= '0;
      fault_q <= 1'b0;
      wb_q    <= 1'b0;
    end else begin
      fault_q <= scan_go && hit_any;
      wb_q    <= st_real && st_cond_i;
      if (viol_q && viol_take_i) begin
        viol_q <= 1'b0;
      end else if (scan_go && hit_any) begin
        viol_q <= 1'b1;
        idx_q  <= hit_idx;
      end
    end
  end

  assign viol_valid_o = viol_q;
  assign viol_idx_o   = idx_q;
  assign fault_o      = fault_q;
  assign wb_inc_o     = wb_q;

endmodule

// File: rtl/ordering_guard_checker.sv
module ordering_guard_checker #(
  parameter int IDX_W  = 3,
  parameter int SIZE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid_i,
  input logic [IDX_W-1:0]  st_lq_pos_i,
  input logic [SIZE_W-1:0] st_size_i,
  input logic              st_cond_i,
  input logic [IDX_W-1:0]  lq_tail_i,
  input logic              viol_take_i,
  input logic              viol_valid_o,
  input logic [IDX_W-1:0]  viol_idx_o,
  input logic              fault_o,
  input logic              wb_inc_o,
  input logic              scan_go,
  input logic              hit_any
);

  // R1: a scan that finds a hit produces a fault on the next cycle
  assert_fault_on_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    scan_go && hit_any |=> fault_o);

  // R1: a fault always comes with a latched violator
  assert_fault_has_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> viol_valid_o);

  // R2: empty range never faults
  assert_empty_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid_i && (st_lq_pos_i == lq_tail_i) |=> !fault_o);

  // R5: latched state suppresses further faults
  assert_no_scan_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid_o |=> !fault_o);

  // R5 / R6: index held until collected
  assert_hold_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid_o && !viol_take_i |=> viol_valid_o && $stable(viol_idx_o));

  // R6: take clears the latch
  assert_take_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid_o && viol_take_i |=> !viol_valid_o);

  // R7: zero-size store has no effect
  assert_zero_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid_i && (st_size_i == '0) |=> !fault_o && !wb_inc_o);

  // R8: writeback pulse only follows a conditional store request
  assert_wb_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_inc_o |-> $past(st_valid_i && st_cond_i));

endmodule

bind ordering_guard ordering_guard_checker #(.IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .st_valid_i   (st_valid_i),
  .st_lq_pos_i  (st_lq_pos_i),
  .st_size_i    (st_size_i),
  .st_cond_i    (st_cond_i),
  .lq_tail_i    (lq_tail_i),
  .viol_take_i  (viol_take_i),
  .viol_valid_o (viol_valid_o),
  .viol_idx_o   (viol_idx_o),
  .fault_o      (fault_o),
  .wb_inc_o     (wb_inc_o),
  .scan_go      (scan_go),
  .hit_any      (hit_any)
);

// File: tb/ordering_guard_bench.sv
module ordering_guard_bench;

  localparam int D = 8;
  localparam int AW = 32;
  localparam logic [31:0] INV = 32'hFFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0;
  logic [2:0]    st_pos = '0;
  logic [31:0]   st_addr = '0;
  logic [3:0]    st_size = '0;
  logic          st_cond = 1'b0;
  logic [2:0]    lq_tail = '0;
  logic [31:0]   lq_mem [D];
  logic [D*AW-1:0] lq_flat;
  logic          take = 1'b0;
  logic          viol_valid;
  logic [2:0]    viol_idx;
  logic          fault;
  logic          wb_inc;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string cur_req = "R10";

  // reference model state
  bit    m_valid = 0;
  int    m_idx = 0;
  bit    m_fault = 0;
  bit    m_wb = 0;
  string m_req = "R10";

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < D; i++) lq_flat[i*AW +: AW] = lq_mem[i];
  end

  ordering_guard u_ordering_guard (
    .clk(clk), .rst_n(rst_n),
    .st_valid_i(st_valid), .st_lq_pos_i(st_pos), .st_addr_i(st_addr),
    .st_size_i(st_size), .st_cond_i(st_cond), .lq_tail_i(lq_tail),
    .lq_addr_i(lq_flat), .viol_take_i(take),
    .viol_valid_o(viol_valid), .viol_idx_o(viol_idx),
    .fault_o(fault), .wb_inc_o(wb_inc)
  );

  // Behavioural model: walk the ring slot by slot, first hit wins.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_idx = 0; m_fault = 0; m_wb = 0; m_req = "R10";
    end else begin
      bit old_valid;
      int found;
      old_valid = m_valid;
      m_fault = 0;
      m_wb = 0;
      m_req = cur_req;
      if (take && old_valid) m_valid = 0;
      if (st_valid && st_size != 0) begin
        if (st_cond) m_wb = 1;
        if (!old_valid) begin
          found = -1;
          for (int k = 0; k < D; k++) begin
            int slot;
            slot = (int'(st_pos) + k) % D;
            if (slot == int'(lq_tail)) break;
            if (lq_mem[slot] != INV && (lq_mem[slot] >> 8) == (st_addr >> 8)) begin
              found = slot;
              break;
            end
          end
          if (found >= 0) begin
            m_valid = 1; m_idx = found; m_fault = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (fault !== m_fault || wb_inc !== m_wb || viol_valid !== m_valid ||
          (m_valid && int'(viol_idx) != m_idx)) begin
        failures++;
        $display("FAIL %s: actual fault=%0b wb=%0b valid=%0b idx=%0d expected fault=%0b wb=%0b valid=%0b idx=%0d",
                 m_req, fault, wb_inc, viol_valid, viol_idx, m_fault, m_wb, m_valid, m_idx);
      end
    end
  end

  task automatic clear_lq();
    for (int i = 0; i < D; i++) lq_mem[i] = INV;
  endtask

  // Issue one store (inputs are changed 2 ns after a rising edge), then one idle cycle.
  task automatic do_store(input int pos, input int tail, input logic [31:0] a,
                          input int sz, input bit cnd, input bit tk, input string req);
    cur_req = req;
    st_valid = 1; st_pos = 3'(pos); lq_tail = 3'(tail); st_addr = a;
    st_size = 4'(sz); st_cond = cnd; take = tk;
    @(posedge clk); #2;
    st_valid = 0; take = 0; st_cond = 0;
    @(posedge clk); #2;
  endtask

  task automatic do_take(input string req);
    cur_req = req;
    take = 1;
    @(posedge clk); #2;
    take = 0;
    @(posedge clk); #2;
  endtask

  initial begin
    clear_lq();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2;

    // R1: single match inside range, then collect (R6)
    lq_mem[3] = 32'h1234_5610;
    do_store(1, 5, 32'h1234_56FC, 4, 0, 0, "R1");
    do_take("R6");

    // R3: same upper bits but differs at bit 8 -> no match; low bits only -> match
    do_store(1, 5, 32'h1234_5710, 4, 0, 0, "R3");
    do_store(1, 5, 32'h1234_5600, 1, 0, 0, "R3");
    do_take("R6");

    // R4: two matches, nearest to start wins; then across the wrap point
    clear_lq();
    lq_mem[2] = 32'h0000_A004; lq_mem[4] = 32'h0000_A0F0;
    do_store(1, 6, 32'h0000_A080, 8, 0, 0, "R4");
    do_take("R4");
    clear_lq();
    lq_mem[7] = 32'h0000_B010; lq_mem[1] = 32'h0000_B020;
    do_store(6, 3, 32'h0000_B0FF, 8, 0, 0, "R4");

    // R5: latched, another matching store is ignored
    do_store(0, 3, 32'h0000_B000, 8, 0, 0, "R5");
    do_take("R6");

    // R2: empty range, match exactly at tail, match before start
    do_store(1, 1, 32'h0000_B000, 8, 0, 0, "R2");
    do_store(2, 7, 32'h0000_B000, 8, 0, 0, "R2");
    do_store(0, 1, 32'h0000_B000, 8, 0, 0, "R2");

    // R7: zero-size store with a match and conditional flag
    do_store(6, 3, 32'h0000_B000, 0, 1, 0, "R7");

    // R8: conditional with match, then conditional while latched
    do_store(6, 3, 32'h0000_B000, 4, 1, 0, "R8");
    do_store(6, 3, 32'h0000_B000, 4, 1, 0, "R8");
    do_take("R8");

    // R9: invalid slot in range, store in the all-ones region
    clear_lq();
    do_store(0, 7, 32'hFFFF_FF00, 4, 0, 0, "R9");

    // Random mix, model compared every cycle
    for (int n = 0; n < 600; n++) begin
      for (int i = 0; i < D; i++) begin
        int r;
        r = $urandom % 4;
        lq_mem[i] = (r == 3) ? INV : {20'h00010 + 20'(r), 4'h0, 8'($urandom)};
      end
      cur_req = "R4";
      st_valid = $urandom % 2;
      st_pos = 3'($urandom);
      lq_tail = 3'($urandom);
      st_addr = {20'h00010 + 20'($urandom % 3), 4'h0, 8'($urandom)};
      st_size = 4'($urandom % 3);
      st_cond = $urandom % 2;
      take = ($urandom % 3) == 0;
      @(posedge clk); #2;
    end
    st_valid = 0; take = 0;
    @(posedge clk); #2;
    @(negedge clk); #1;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: actual running expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule